// File: doc/BRIEF.md
# Carry-Select Four-Function Integer ALU

This block is a purely combinational 32-bit arithmetic and logic unit for an integer datapath. It offers exactly four operations: addition, bitwise OR, bitwise XOR and bitwise AND. There is no dedicated subtract opcode. A subtraction is an addition in which one operand is complemented and the incoming carry is complemented as well.

Each operand passes through a preparation stage before it reaches the function logic. The A operand can be forced to zero, then shifted by one place, then complemented, in that order. The B operand can be complemented on its own. The adder divides the word into equal slices. Every slice above the lowest one computes its sum twice, once for an incoming carry of 0 and once for an incoming carry of 1. The real carry arriving at the slice then picks one of the two results. This keeps the slowest path to roughly one slice ripple plus one multiplexer per slice. Four flags are produced with the result: negative, zero, carry and overflow.

Top module: `alu_cs32`

## Requirements
- R1: With function code 0 (add), the result equals A' + B' + cin' modulo 2^32, where A' and B' are the prepared operands and cin' is the effective carry-in.
- R2: Function code 1 gives A' OR B', code 2 gives A' XOR B', and code 3 gives A' AND B'.
- R3: For add, the overflow flag is 1 exactly when A' and B' have the same bit 31 and the result's bit 31 differs from it. This is the XOR of the carries into and out of bit 31.
- R4: For add, the carry flag is the carry out of bit 31.
- R5: For the three logical functions, the carry and overflow flags are both 0, whatever the carry-in.
- R6: The negative flag equals result bit 31. The zero flag is 1 exactly when all 32 result bits are 0.
- R7: Setting inv_a_i complements every bit of the prepared A. Setting inv_b_i complements every bit of B. The two controls are independent.
- R8: Setting zero_a_i replaces A with 0 before the shift and before the complement. With inv_a_i also set, A' is therefore all ones.
- R9: The shift code applies to A after zeroing: 0 leaves A unchanged, 1 shifts logically right by one, 2 shifts arithmetically right by one (bit 31 is kept), and 3 shifts left by one, filling with 0.
- R10: The effective carry-in is carry_in_i XOR inv_cin_i. With inv_b_i=1, inv_cin_i=1 and carry_in_i=0, the result is A' - B' and the carry flag is 1 when no borrow occurs.
- R11: Carries propagate correctly across every slice boundary. Examples: 0x000000FF+1 gives 0x00000100, and 0xFFFFFFFF+1 gives 0 with carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| inv_a_i | input | 1 | Complement prepared A |
| inv_b_i | input | 1 | Complement B |
| zero_a_i | input | 1 | Replace A with zero |
| shift_sel_i | input | 2 | A shift code (0 none, 1 logical right, 2 arithmetic right, 3 left) |
| fn_sel_i | input | 2 | Function code (0 add, 1 or, 2 xor, 3 and) |
| carry_in_i | input | 1 | Carry into bit 0 |
| inv_cin_i | input | 1 | Complement the carry-in |
| result_o | output | 32 | Function result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag (add only) |
| flag_v_o | output | 1 | Overflow flag (add only) |

## Verification
The embedded checks assume every control input holds a defined 0 or 1 value while the outputs are being evaluated, because the block has no state and reacts to any input value at once. The checks place no other condition on the inputs, since every combination of operands, codes and controls is legal. The bench therefore drives all controls to known values before each comparison, including the reset-time pattern. It then samples half a cycle later, once the combinational outputs have settled. The stimulus mixes directed slice-boundary and subtraction cases with random operands. Every control field is drawn across its full range.

// File: rtl/alu_cs_pkg.sv
package alu_cs_pkg;
   typedef enum logic [1:0] {
      FN_ADD = 2'd0,
      FN_OR  = 2'd1,
      FN_XOR = 2'd2,
      FN_AND = 2'd3
   } alu_fn_e;

   typedef enum logic [1:0] {
      SH_PASS = 2'd0,
      SH_SRL1 = 2'd1,
      SH_SRA1 = 2'd2,
      SH_SLL1 = 2'd3
   } a_shift_e;
endpackage

// File: rtl/csa_opnd_prep.sv
module csa_opnd_prep #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_raw,
   input  logic [WIDTH-1:0] b_raw,
   input  logic             zero_a,
   input  logic             inv_a,
   input  logic             inv_b,
   input  logic [1:0]       shift_sel,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] b_out
);
   import alu_cs_pkg::*;
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] a_z;
   logic [WIDTH-1:0] a_sh;

   if (WIDTH < 2) begin : g_bad_width
      $error("csa_opnd_prep: WIDTH must be at least 2");
   end

   always_comb begin
      a_z = zero_a ? '0 : a_raw;
      case (a_shift_e'(shift_sel))
         SH_SRL1: a_sh = {1'b0, a_z[MSB:1]};
         SH_SRA1: a_sh = {a_z[MSB], a_z[MSB:1]};
         SH_SLL1: a_sh = {a_z[MSB-1:0], 1'b0};
         default: a_sh = a_z;
      endcase
      a_out = a_sh ^ {WIDTH{inv_a}};
      b_out = b_raw ^ {WIDTH{inv_b}};
   end

   // zeroing happens ahead of shift and complement
   always_comb begin
      if (zero_a) begin
         assert_zero_first_R8: assert (a_out == {WIDTH{inv_a}})
            else $error("zeroed A not constant after prep");
      end
   end
endmodule

// File: rtl/csa_slice.sv
module csa_slice #(
   parameter int SW        = 8,
   parameter bit SPECULATE = 1'b1
) (
   input  logic [SW-1:0] a,
   input  logic [SW-1:0] b,
   input  logic          cin,
   output logic [SW-1:0] sum,
   output logic          cout
);
   function automatic logic [SW:0] ripple(input logic [SW-1:0] x,
                                          input logic [SW-1:0] y,
                                          input logic ci);
      logic          c;
      logic [SW-1:0] s;
      c = ci;
      for (int i = 0; i < SW; i++) begin
         s[i] = x[i] ^ y[i] ^ c;
         c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
      end
      return {c, s};
   endfunction

   if (SW < 1) begin : g_bad_sw
      $error("csa_slice: SW must be positive");
   end

   if (SPECULATE) begin : g_select
      logic [SW:0] chain0;
      logic [SW:0] chain1;
      always_comb begin
         chain0 = ripple(a, b, 1'b0);
         chain1 = ripple(a, b, 1'b1);
         {cout, sum} = cin ? chain1 : chain0;
      end
      // a carry out with carry-in 0 must also appear with carry-in 1
      always_comb begin
         if (chain0[SW]) begin
            assert_spec_mono_R11: assert (chain1[SW])
               else $error("speculative chains disagree");
         end
      end
   end else begin : g_ripple
      always_comb {cout, sum} = ripple(a, b, cin);
   end
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
   parameter int WIDTH   = 32,
   parameter int SLICE_W = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             c_msb
);
   localparam int NS  = WIDTH / SLICE_W;
   localparam int MSB = WIDTH - 1;

   if ((WIDTH % SLICE_W) != 0 || SLICE_W < 1) begin : g_bad_split
      $error("csa_adder: WIDTH must be a multiple of SLICE_W");
   end

   logic [NS:0] carry;
   assign carry[0] = cin;

   for (genvar g = 0; g < NS; g++) begin : g_slice
      csa_slice #(
         .SW        (SLICE_W),
         .SPECULATE (g != 0)
      ) u_slice (
         .a    (a[g*SLICE_W +: SLICE_W]),
         .b    (b[g*SLICE_W +: SLICE_W]),
         .cin  (carry[g]),
         .sum  (sum[g*SLICE_W +: SLICE_W]),
         .cout (carry[g+1])
      );
   end

   assign cout  = carry[NS];
   assign c_msb = a[MSB] ^ b[MSB] ^ sum[MSB];

   always_comb begin
      assert_slice_sum_R1: assert ({cout, sum} ==
            ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
         else $error("sliced sum differs from full-width sum");
   end
endmodule

// File: rtl/alu_cs32.sv
module alu_cs32 #(
   parameter int WIDTH   = 32,
   parameter int SLICE_W = 8
) (
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic             inv_a_i,
   input  logic             inv_b_i,
   input  logic             zero_a_i,
   input  logic [1:0]       shift_sel_i,
   input  logic [1:0]       fn_sel_i,
   input  logic             carry_in_i,
   input  logic             inv_cin_i,
   output logic [WIDTH-1:0] result_o,
   output logic             flag_n_o,
   output logic             flag_z_o,
   output logic             flag_c_o,
   output logic             flag_v_o
);
   import alu_cs_pkg::*;
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] a_p;
   logic [WIDTH-1:0] b_p;
   logic [WIDTH-1:0] add_sum;
   logic             add_cout;
   logic             add_cmsb;
   logic             cin_eff;
   alu_fn_e          fn;

   assign cin_eff = carry_in_i ^ inv_cin_i;
   assign fn      = alu_fn_e'(fn_sel_i);

   csa_opnd_prep #(.WIDTH(WIDTH)) u_prep (
      .a_raw     (opa_i),
      .b_raw     (opb_i),
      .zero_a    (zero_a_i),
      .inv_a     (inv_a_i),
      .inv_b     (inv_b_i),
      .shift_sel (shift_sel_i),
      .a_out     (a_p),
      .b_out     (b_p)
   );

   csa_adder #(.WIDTH(WIDTH), .SLICE_W(SLICE_W)) u_add (
      .a     (a_p),
      .b     (b_p),
      .cin   (cin_eff),
      .sum   (add_sum),
      .cout  (add_cout),
      .c_msb (add_cmsb)
   );

   always_comb begin
      case (fn)
         FN_OR:   result_o = a_p | b_p;
         FN_XOR:  result_o = a_p ^ b_p;
         FN_AND:  result_o = a_p & b_p;
         default: result_o = add_sum;
      endcase
      flag_n_o = result_o[MSB];
      flag_z_o = ~|result_o;
      flag_c_o = (fn == FN_ADD) & add_cout;
      flag_v_o = (fn == FN_ADD) & (add_cout ^ add_cmsb);
   end

   always_comb begin
      if (fn != FN_ADD) begin
         assert_logic_cv_R5: assert (!flag_c_o && !flag_v_o)
            else $error("carry/overflow set on logical op");
      end else begin
         assert_no_overflow_R3: assert (flag_v_o ==
               ((a_p[MSB] == b_p[MSB]) && (add_sum[MSB] != a_p[MSB])))
            else $error("overflow flag disagrees with operand signs");
      end
      if (flag_z_o) begin
         assert_zero_not_neg_R6: assert (!flag_n_o)
            else $error("zero and negative both set");
      end
   end
endmodule

// File: tb/alu_cs32_bench.sv
module alu_cs32_bench;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] opa, opb;
   logic         inv_a, inv_b, zero_a, cin, inv_cin;
   logic [1:0]   shift_sel, fn_sel;
   logic [W-1:0] result;
   logic         fn_n, fn_z, fn_c, fn_v;
   int           n_tests = 0;
   int           n_fail  = 0;
   bit           done    = 1'b0;

   always #2.5 clk = ~clk;

   alu_cs32 u_alu_cs32 (
      .opa_i (opa), .opb_i (opb), .inv_a_i (inv_a), .inv_b_i (inv_b),
      .zero_a_i (zero_a), .shift_sel_i (shift_sel), .fn_sel_i (fn_sel),
      .carry_in_i (cin), .inv_cin_i (inv_cin), .result_o (result),
      .flag_n_o (fn_n), .flag_z_o (fn_z), .flag_c_o (fn_c), .flag_v_o (fn_v)
   );

   // reference model built from the requirements: {res, n, z, c, v}
   function automatic logic [W+3:0] model(
         input logic [W-1:0] a, input logic [W-1:0] b,
         input logic ia, input logic ib, input logic za,
         input logic [1:0] sh, input logic [1:0] fn,
         input logic ci, input logic ic);
      logic [W-1:0] ap, bp, r;
      logic [W:0]   s;
      logic         c, v;
      ap = za ? '0 : a;
      case (sh)
         2'd1:    ap = ap >> 1;
         2'd2:    ap = {ap[W-1], ap[W-1:1]};
         2'd3:    ap = ap << 1;
         default: ap = ap;
      endcase
      if (ia) ap = ~ap;
      bp = ib ? ~b : b;
      s  = {1'b0, ap} + {1'b0, bp} + {{W{1'b0}}, (ci ^ ic)};
      c = 1'b0; v = 1'b0;
      case (fn)
         2'd0: begin
            r = s[W-1:0]; c = s[W];
            v = (ap[W-1] == bp[W-1]) && (r[W-1] != ap[W-1]);
         end
         2'd1:    r = ap | bp;
         2'd2:    r = ap ^ bp;
         default: r = ap & bp;
      endcase
      return {r, r[W-1], (r == '0), c, v};
   endfunction

   task automatic run(input string tag, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic ia, input logic ib,
                      input logic za, input logic [1:0] sh, input logic [1:0] fn,
                      input logic ci, input logic ic);
      logic [W+3:0] exp_v, got;
      @(posedge clk);
      opa = a; opb = b; inv_a = ia; inv_b = ib; zero_a = za;
      shift_sel = sh; fn_sel = fn; cin = ci; inv_cin = ic;
      @(negedge clk);
      exp_v = model(a, b, ia, ib, za, sh, fn, ci, ic);
      got   = {result, fn_n, fn_z, fn_c, fn_v};
      n_tests++;
      if (got !== exp_v) begin
         n_fail++;
         $display("FAIL %s: got res=%h nzcv=%b exp res=%h nzcv=%b",
                  tag, got[W+3:4], got[3:0], exp_v[W+3:4], exp_v[3:0]);
      end
   endtask

   task automatic check_val(input string tag, input logic [W+3:0] exp_v);
      n_tests++;
      if ({result, fn_n, fn_z, fn_c, fn_v} !== exp_v) begin
         n_fail++;
         $display("FAIL %s: got res=%h nzcv=%b exp res=%h nzcv=%b", tag,
                  result, {fn_n, fn_z, fn_c, fn_v}, exp_v[W+3:4], exp_v[3:0]);
      end
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      opa = '0; opb = '0; inv_a = 0; inv_b = 0; zero_a = 0;
      shift_sel = 0; fn_sel = 0; cin = 0; inv_cin = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 reset-time pattern: all zero in, zero flag out
      check_val("R6 reset", {32'h0, 4'b0100});
      // R11 slice boundaries
      run("R11 byte carry", 32'h0000_00FF, 32'h1, 0,0,0, 2'd0, 2'd0, 0,0);
      check_val("R11 byte carry", {32'h0000_0100, 4'b0000});
      run("R11 multi slice", 32'h00FF_FFFF, 32'h1, 0,0,0, 2'd0, 2'd0, 0,0);
      check_val("R11 multi slice", {32'h0100_0000, 4'b0000});
      run("R4 wrap", 32'hFFFF_FFFF, 32'h1, 0,0,0, 2'd0, 2'd0, 0,0);
      check_val("R4 wrap", {32'h0, 4'b0110});
      run("R3 overflow", 32'h7FFF_FFFF, 32'h1, 0,0,0, 2'd0, 2'd0, 0,0);
      check_val("R3 overflow", {32'h8000_0000, 4'b1001});
      // R10 subtraction
      run("R10 sub borrow", 32'd5, 32'd7, 0,1,0, 2'd0, 2'd0, 0,1);
      check_val("R10 sub borrow", {32'hFFFF_FFFE, 4'b1000});
      run("R10 sub", 32'd7, 32'd5, 0,1,0, 2'd0, 2'd0, 0,1);
      check_val("R10 sub", {32'd2, 4'b0010});
      // R8 zero A, R7 inversion
      run("R8 zero", 32'hDEAD_BEEF, 32'h1234_5678, 0,0,1, 2'd2, 2'd0, 0,0);
      check_val("R8 zero", {32'h1234_5678, 4'b0000});
      run("R8 zero inv", 32'hDEAD_BEEF, 32'h1234_5678, 1,0,1, 2'd1, 2'd3, 0,0);
      check_val("R8 zero inv", {32'h1234_5678, 4'b0000});
      run("R7 inv a", 32'h0, 32'h0, 1,0,0, 2'd0, 2'd1, 0,0);
      check_val("R7 inv a", {32'hFFFF_FFFF, 4'b1000});
      run("R7 inv b", 32'hF0F0_F0F0, 32'h0F0F_0F0F, 0,1,0, 2'd0, 2'd2, 0,0);
      check_val("R7 inv b", {32'h0, 4'b0100});
      // R9 shifts
      run("R9 srl", 32'h8000_0003, 32'h0, 0,0,0, 2'd1, 2'd1, 0,0);
      check_val("R9 srl", {32'h4000_0001, 4'b0000});
      run("R9 sra", 32'h8000_0003, 32'h0, 0,0,0, 2'd2, 2'd1, 0,0);
      check_val("R9 sra", {32'hC000_0001, 4'b1000});
      run("R9 sll", 32'h8000_0003, 32'h0, 0,0,0, 2'd3, 2'd1, 0,0);
      check_val("R9 sll", {32'h0000_0006, 4'b0000});
      // R5 / R2 logical ops ignore carry-in
      run("R5 and", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0,0,0, 2'd0, 2'd3, 1,0);
      check_val("R5 and", {32'hFFFF_FFFF, 4'b1000});
      run("R2 xor", 32'hA5A5_0000, 32'h5A5A_0000, 0,0,0, 2'd0, 2'd2, 1,1);
      check_val("R2 xor", {32'hFFFF_0000, 4'b1000});
      // random sweep over all fields, R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
      void'($urandom(32'd1990));
      for (int i = 0; i < 1500; i++) begin
         logic [31:0] ra, rb, rc;
         ra = $urandom(); rb = $urandom(); rc = $urandom();
         if (rc[12]) rb = ~ra;
         run("R1 random", ra, rb, rc[0], rc[1], rc[2] & rc[3],
             rc[5:4], rc[7:6], rc[8], rc[9]);
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule